// File: doc/BRIEF.md
# Half-Bridge Short-Circuit Filter and Fault Diagnosis

This block watches the fault inputs of a two-leg MOSFET bridge driver and decides which gates may be driven. Each of the four switches has its own desaturation flag. A flag must stay high for an unbroken, programmable run of clock cycles before it counts as a confirmed short. Any gap restarts that switch's run from zero, so short glitches never add up. A confirmed short latches both switches of its leg off. The latch holds until a diagnosis clear pulse or a sleep request.

Each leg also has an undervoltage flag. It holds both gates of that leg off only for as long as it is high, and the gates come back on their own. An overtemperature warning only changes the diagnosis code. The code leaves the block as two active-high pull-down enables for open-drain error pins. A pin reads low while its enable is 1. Sleep puts the whole block back to its start state.

Top module: `bridge_fault_supervisor`

## Requirements
- R1: With filter length L on `filt_len_i` (0 is treated as 1), a switch's flag that is high for L consecutive sampled cycles confirms a short. Its leg's gate enables are 0 from the cycle after the L-th high sample.
- R2: A flag that goes low before the L-th sample resets that switch's run to zero. Later high cycles start a fresh count, so interrupted exposure never confirms a short.
- R3: A confirmed short clears both gate enables of its leg (switch bits 2h and 2h+1 belong to leg h). The other leg is untouched, and the latch holds while the flag is gone until a clear or sleep.
- R4: `diag_clr_i` clears every short latch and every run counter at the next edge. A confirmation in the same cycle as the clear is discarded, and a short that persists must run a full filter length again.
- R5: `uv_i[h]` high forces both gate enables of leg h to 0 in the same cycle, with no clock. They return the cycle the flag falls, unless a short latch holds them.
- R6: Diagnosis code as {er1_pull_o, er2_pull_o}, priority highest first: any undervoltage 11 (both pins low); else any short latch 10 (first pin low); else overtemperature 01 (second pin low); else 00. A short latch stays set while undervoltage masks it.
- R7: `otw_i` never changes any gate enable.
- R8: While `sleep_i` is high, all gate enables and both pull enables are 0, and all latches and run counters clear. After reset or sleep, every gate is enabled with code 00.
- R9: Run counts are per switch. Flags of the two switches in one leg that alternate never combine into a confirmation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Sleep: full reinitialisation, all outputs released/off |
| diag_clr_i | input | 1 | Diagnosis clear pulse for short latches and counters |
| filt_len_i | input | CNT_W | Short-circuit filter length in cycles |
| desat_i | input | 2*N_LEG | Per-switch desaturation flags; bit 2h high side, 2h+1 low side of leg h |
| uv_i | input | N_LEG | Per-leg undervoltage flags |
| otw_i | input | 1 | Overtemperature warning |
| gate_en_o | output | 2*N_LEG | Per-switch gate drive permission |
| er1_pull_o | output | 1 | Pull-down enable of the shutdown error pin |
| er2_pull_o | output | 1 | Pull-down enable of the cause/warning pin |

## Verification
Two events can land in the same cycle: a filter run reaching its length and a diagnosis clear, or a confirmed short and an undervoltage on the same leg. A directed test times the clear onto the exact cycle of confirmation and expects the latch to stay empty and a fresh full run to be needed. Another holds undervoltage over a latched short and expects code 11, then code 10 after the undervoltage falls. Random stimulus mixes flags, clears, sleep and filter lengths, and a cycle model in the bench judges every cycle.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

  typedef enum logic [1:0] {
    CODE_NONE  = 2'b00,
    CODE_WARN  = 2'b01,
    CODE_SHORT = 2'b10,
    CODE_UV    = 2'b11
  } diag_code_e;

  // True when the current high sample completes the run (length 0 acts as 1).
  function automatic logic filter_due(input int unsigned run, input int unsigned len);
    int unsigned eff;
    eff = (len == 0) ? 1 : len;
    return (run + 1) >= eff;
  endfunction

  // Maps a code onto {first pin pull, second pin pull}.
  function automatic logic [1:0] code_to_pulls(input diag_code_e c);
    return logic'(c[1]) ? {1'b1, c[0]} : {1'b0, c[0]};
  endfunction

endpackage

// File: rtl/desat_filter.sv
module desat_filter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             flag_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             trip_o,
  output logic [CNT_W-1:0] run_o
);
  import bfs_pkg::*;

  localparam logic [CNT_W-1:0] RUN_MAX = '1;

  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             run_q <= '0;
    else if (flush_i)       run_q <= '0;
    else if (!flag_i)       run_q <= '0;
    else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
  end

  assign trip_o = flag_i && filter_due(32'(run_q), 32'(len_i));
  assign run_o  = run_q;

endmodule

// File: rtl/leg_latch.sv
module leg_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic flush_i,
  input  logic set_i,
  output logic lat_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lat_o <= 1'b0;
    else if (flush_i) lat_o <= 1'b0;
    else if (set_i)   lat_o <= 1'b1;
  end
endmodule

// File: rtl/diag_encoder.sv
module diag_encoder #(
  parameter int N_LEG = 2
) (
  input  logic             sleep_i,
  input  logic [N_LEG-1:0] uv_i,
  input  logic [N_LEG-1:0] lat_i,
  input  logic             otw_i,
  output bfs_pkg::diag_code_e code_o,
  output logic             er1_pull_o,
  output logic             er2_pull_o
);
  import bfs_pkg::*;

  always_comb begin
    if (sleep_i)        code_o = CODE_NONE;
    else if (|uv_i)     code_o = CODE_UV;
    else if (|lat_i)    code_o = CODE_SHORT;
    else if (otw_i)     code_o = CODE_WARN;
    else                code_o = CODE_NONE;
  end

  assign {er1_pull_o, er2_pull_o} = code_to_pulls(code_o);

endmodule

// File: rtl/bridge_fault_supervisor.sv
module bridge_fault_supervisor #(
  parameter int N_LEG = 2,
  parameter int CNT_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_i,
  input  logic               diag_clr_i,
  input  logic [CNT_W-1:0]   filt_len_i,
  input  logic [2*N_LEG-1:0] desat_i,
  input  logic [N_LEG-1:0]   uv_i,
  input  logic               otw_i,
  output logic [2*N_LEG-1:0] gate_en_o,
  output logic               er1_pull_o,
  output logic               er2_pull_o
);
  import bfs_pkg::*;

  localparam int N_SW = 2 * N_LEG;

  logic                        flush;
  logic [N_SW-1:0]             trip_evt;
  logic [N_SW-1:0][CNT_W-1:0]  run_cnt;
  logic [N_LEG-1:0]            short_lat;
  diag_code_e                  diag_code;

  assign flush = sleep_i | diag_clr_i;

  for (genvar s = 0; s < N_SW; s++) begin : g_sw
    desat_filter #(.CNT_W(CNT_W)) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (flush),
      .flag_i  (desat_i[s]),
      .len_i   (filt_len_i),
      .trip_o  (trip_evt[s]),
      .run_o   (run_cnt[s])
    );
  end

  for (genvar h = 0; h < N_LEG; h++) begin : g_leg
    leg_latch u_lat (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (flush),
      .set_i   (|trip_evt[2*h +: 2]),
      .lat_o   (short_lat[h])
    );
    assign gate_en_o[2*h +: 2] = {2{!sleep_i && !short_lat[h] && !uv_i[h]}};
  end

  diag_encoder #(.N_LEG(N_LEG)) u_enc (
    .sleep_i    (sleep_i),
    .uv_i       (uv_i),
    .lat_i      (short_lat),
    .otw_i      (otw_i),
    .code_o     (diag_code),
    .er1_pull_o (er1_pull_o),
    .er2_pull_o (er2_pull_o)
  );

endmodule

// File: rtl/bfs_checker.sv
module bfs_checker #(
  parameter int N_LEG = 2,
  parameter int CNT_W = 10
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             sleep_i,
  input logic                             diag_clr_i,
  input logic [2*N_LEG-1:0]               desat_i,
  input logic [N_LEG-1:0]                 uv_i,
  input logic [2*N_LEG-1:0]               gate_en_o,
  input logic                             er1_pull_o,
  input logic                             er2_pull_o,
  input logic [2*N_LEG-1:0]               trip_evt,
  input logic [2*N_LEG-1:0][CNT_W-1:0]    run_cnt,
  input logic [N_LEG-1:0]                 short_lat
);
  localparam int N_SW = 2 * N_LEG;

  for (genvar s = 0; s < N_SW; s++) begin : g_sw_chk
    p_trip_needs_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
      trip_evt[s] |-> desat_i[s]);
    p_gap_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !desat_i[s] |=> (run_cnt[s] == '0));
  end

  for (genvar h = 0; h < N_LEG; h++) begin : g_leg_chk
    p_trip_latches_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((|trip_evt[2*h +: 2]) && !diag_clr_i && !sleep_i) |=>
        (short_lat[h] && gate_en_o[2*h +: 2] == 2'b00));
    p_latch_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (short_lat[h] && !diag_clr_i && !sleep_i) |=> short_lat[h]);
    p_uv_gates_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      uv_i[h] |-> (gate_en_o[2*h +: 2] == 2'b00));
  end

  p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    diag_clr_i |=> (short_lat == '0));
  p_uv_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|uv_i) && !sleep_i) |-> (er1_pull_o && er2_pull_o));
  p_warn_no_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && uv_i == '0 && short_lat == '0) |-> (gate_en_o == '1));
  p_sleep_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |-> (gate_en_o == '0 && !er1_pull_o && !er2_pull_o));

endmodule

bind bridge_fault_supervisor bfs_checker #(.N_LEG(N_LEG), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sleep_i    (sleep_i),
  .diag_clr_i (diag_clr_i),
  .desat_i    (desat_i),
  .uv_i       (uv_i),
  .gate_en_o  (gate_en_o),
  .er1_pull_o (er1_pull_o),
  .er2_pull_o (er2_pull_o),
  .trip_evt   (trip_evt),
  .run_cnt    (run_cnt),
  .short_lat  (short_lat)
);

// File: tb/tb_bridge_fault_supervisor.sv
module tb_bridge_fault_supervisor;
  localparam int N_LEG = 2;
  localparam int CNT_W = 10;
  localparam int N_SW  = 2 * N_LEG;
  localparam int RUN_CAP = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_i = 1'b0, diag_clr_i = 1'b0, otw_i = 1'b0;
  logic [CNT_W-1:0] filt_len_i = 10'd5;
  logic [N_SW-1:0]  desat_i = '0;
  logic [N_LEG-1:0] uv_i = '0;
  logic [N_SW-1:0]  gate_en_o;
  logic             er1_pull_o, er2_pull_o;

  int checks = 0, errors = 0;
  int m_run[N_SW];
  bit m_lat[N_LEG];

  always #10 clk = ~clk;

  bridge_fault_supervisor #(.N_LEG(N_LEG), .CNT_W(CNT_W)) dut (.*);

  function automatic logic [N_SW-1:0] exp_gates();
    logic [N_SW-1:0] g;
    for (int s = 0; s < N_SW; s++)
      g[s] = !sleep_i && !m_lat[s/2] && !uv_i[s/2];
    return g;
  endfunction

  function automatic logic [1:0] exp_pulls();
    bit any_lat = 0;
    for (int h = 0; h < N_LEG; h++) any_lat |= m_lat[h];
    if (sleep_i) return 2'b00;
    if (|uv_i)   return 2'b11;
    if (any_lat) return 2'b10;
    if (otw_i)   return 2'b01;
    return 2'b00;
  endfunction

  function automatic void model_step();
    int eff;
    eff = (filt_len_i == 0) ? 1 : int'(filt_len_i);
    if (sleep_i || diag_clr_i) begin
      for (int s = 0; s < N_SW; s++) m_run[s] = 0;
      for (int h = 0; h < N_LEG; h++) m_lat[h] = 0;
    end else begin
      for (int s = 0; s < N_SW; s++) begin
        if (desat_i[s] && (m_run[s] + 1 >= eff)) m_lat[s/2] = 1;
        if (!desat_i[s]) m_run[s] = 0;
        else if (m_run[s] < RUN_CAP) m_run[s] = m_run[s] + 1;
      end
    end
  endfunction

  // Inputs are set at a negedge; outputs checked 2 ns later, model advanced, then next negedge.
  task automatic cyc(input string tag);
    logic [N_SW-1:0] eg;
    logic [1:0] ep;
    #2;
    eg = exp_gates();
    ep = exp_pulls();
    checks++;
    if (gate_en_o !== eg) begin
      errors++;
      $display("FAIL %s gates act=%b exp=%b t=%0t", tag, gate_en_o, eg, $time);
    end
    checks++;
    if ({er1_pull_o, er2_pull_o} !== ep) begin
      errors++;
      $display("FAIL R6 (%s) code act=%b%b exp=%b t=%0t", tag, er1_pull_o, er2_pull_o, ep, $time);
    end
    model_step();
    @(negedge clk);
  endtask

  task automatic quiet();
    desat_i = '0; uv_i = '0; otw_i = 0; diag_clr_i = 0; sleep_i = 0;
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    for (int s = 0; s < N_SW; s++) m_run[s] = 0;
    for (int h = 0; h < N_LEG; h++) m_lat[h] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc("R8");                                   // reset state
    // R1: 5 high samples confirm, 4 do not
    filt_len_i = 10'd5; desat_i = 4'b0001;
    repeat (6) cyc("R1");
    desat_i = '0; repeat (3) cyc("R3");          // latch holds, leg 1 untouched
    diag_clr_i = 1; cyc("R4"); diag_clr_i = 0; cyc("R4");
    // R2: gaps restart the run
    for (int k = 0; k < 4; k++) begin
      desat_i = 4'b0100; repeat (4) cyc("R2");
      desat_i = '0; cyc("R2");
    end
    // R9: alternating switches of one leg
    filt_len_i = 10'd3;
    for (int k = 0; k < 20; k++) begin desat_i = k[0] ? 4'b0010 : 4'b0001; cyc("R9"); end
    desat_i = '0; cyc("R9");
    // R4: clear lands on the confirming cycle, short persists
    desat_i = 4'b1000; cyc("R4"); cyc("R4");
    diag_clr_i = 1; cyc("R4"); diag_clr_i = 0;
    repeat (4) cyc("R4");
    desat_i = '0; diag_clr_i = 1; cyc("R4"); diag_clr_i = 0;
    // R1: length 0 acts as 1
    filt_len_i = 10'd0; desat_i = 4'b0010; cyc("R1"); desat_i = '0; cyc("R1"); cyc("R1");
    // R5/R6: undervoltage over a latched short, then recovery
    uv_i = 2'b01; cyc("R5"); uv_i = 2'b10; cyc("R5"); uv_i = '0; cyc("R5");
    diag_clr_i = 1; cyc("R4"); diag_clr_i = 0;
    // R7: warning alone
    otw_i = 1; repeat (3) cyc("R7"); otw_i = 0; cyc("R7");
    // R8: sleep clears a latch and a partial run
    filt_len_i = 10'd4; desat_i = 4'b0100; repeat (4) cyc("R8");
    desat_i = 4'b0001; repeat (2) cyc("R8");
    sleep_i = 1; cyc("R8"); sleep_i = 0;
    repeat (3) cyc("R8"); desat_i = '0; repeat (2) cyc("R8");
    quiet(); diag_clr_i = 1; cyc("R8"); diag_clr_i = 0;
    // constrained random
    for (int n = 0; n < 4000; n++) begin
      if (n % 250 == 0) filt_len_i = CNT_W'($urandom_range(0, 7));
      for (int s = 0; s < N_SW; s++) if ($urandom_range(0, 3) == 0) desat_i[s] = ~desat_i[s];
      for (int h = 0; h < N_LEG; h++)
        if ($urandom_range(0, 39) == 0) uv_i[h] = ~uv_i[h];
      if ($urandom_range(0, 19) == 0) otw_i = ~otw_i;
      diag_clr_i = ($urandom_range(0, 29) == 0);
      sleep_i    = ($urandom_range(0, 149) == 0);
      cyc("R3");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule